// File: doc/BRIEF.md
# Serial PCS Interface-Mode Configuration Sequencer

This block brings a serial PCS into one of four interface modes (SGMII, QSGMII, PSGMII or USXGMII) without software stepping through the sequence. A one-cycle start pulse carries a mode code, an in-band autonegotiation flag and a channel index. The sequencer then works through the PCS register file as the only master on a simple 32-bit request/acknowledge bus. Every register change is a read-modify-write, so bits outside the targeted fields keep their values.

The full sequence runs as follows. The 10G sub-PCS reset is held. The mode field is written. The analog block gets a reset pulse of fixed length. The sequencer then polls a calibration flag until it reads 1 or a timeout expires. Last come the steps that belong to the chosen mode: the sub-PCS enables for USXGMII, or the per-channel forced-speed bit for the SGMII family.

The last mode that completed is stored. A request for that same mode finishes at once and touches nothing. All wait, poll and timeout intervals are given in milliseconds and converted to clock cycles from a kHz clock parameter.

Top module: `pcs_mode_seq`

## Requirements
- R1: After reset, done_o, err_o, bus_req_o and rate_sel_o are 0, xrst_o is 1 (sub-PCS held), and no mode is stored.
- R2: Mode codes on mode_i are 0 = SGMII, 1 = QSGMII, 2 = PSGMII and 3 = USXGMII. A start with any code from 4 to 7 raises err_o for one cycle, on the cycle after start. It makes no bus access and leaves the stored mode unchanged.
- R3: A start whose valid mode equals the stored mode raises done_o on the cycle after start and makes no bus access.
- R4: A full sequence sets xrst_o to 1 before its first bus write.
- R5: The mode register at 0x46C gets field [12:8] = 0x04 (SGMII), 0x01 (QSGMII), 0x02 (PSGMII) or 0x10 (USXGMII). Bit 0 is cleared for the three SGMII-family modes and kept for USXGMII. All other bits are kept.
- R6: Only one bus transaction is in flight at a time. While bus_req_o is high and bus_ack_i is low, the address, direction and write data hold steady. Each write is preceded by a read of the same address.
- R7: After the mode write, bit 6 of 0x780 is cleared. It stays clear for at least WAIT_MS*CLK_KHZ cycles and is then set again.
- R8: The sequencer then reads 0x1E0. While bit 7 reads 0, it reads again, with at least POLL_MS*CLK_KHZ cycles between reads. A read of 1 lets the sequence go on.
- R9: If bit 7 is still 0 on a read at least TMO_MS*CLK_KHZ cycles after the analog reset was released, err_o pulses and bus activity stops. The stored mode and rate_sel_o stay as they were.
- R10: On calibration success, rate_sel_o becomes 1 (312.5 MHz) for USXGMII and 0 (125 MHz) for the SGMII family.
- R11: For USXGMII, xrst_o drops to 0 and bit 9 of 0x38000 is set. If in-band negotiation is requested, bit 8 of 0x1F8001 and bit 12 of 0x1F0000 are also set; otherwise those two registers are not touched.
- R12: For the SGMII family with in-band negotiation off, bit 3 of the channel control register at 0x480 + 0x18*chan_i is set. With it on, no channel register is touched. xrst_o stays 1 in both cases.
- R13: Completion of a full sequence gives a single-cycle done_o pulse and stores the requested mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request pulse, taken only while idle |
| mode_i | input | 3 | Requested interface mode code |
| inband_i | input | 1 | In-band autonegotiation requested |
| chan_i | input | CH_W (3) | Channel whose control register gets the force bit |
| bus_req_o | output | 1 | Bus request, held until acknowledged |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 24 | Register address |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Transaction acknowledge |
| bus_rdata_i | input | 32 | Read data, valid with acknowledge |
| xrst_o | output | 1 | 10G sub-PCS reset, active high |
| done_o | output | 1 | Sequence complete pulse |
| err_o | output | 1 | Unsupported mode or calibration timeout pulse |
| rate_sel_o | output | 1 | Raw clock rate: 0 = 125 MHz, 1 = 312.5 MHz |

## Verification
Some properties are checked on every cycle. The bus request must hold steady until it is acknowledged. The sub-PCS reset must be high whenever the mode register is written and low whenever the USXGMII enable register is written. The rate select must already show 312.5 MHz when the reset is released. No request may be open when a result is reported. Other behaviour shows only in the bench's scenarios, which run against a register model: that unrelated bits survive each read-modify-write, the minimum length of the analog reset pulse and of the poll gaps, that a calibration timeout leaves the stored mode unchanged, and the zero-access fast path for a repeated mode.

// File: rtl/pcs_seq_pkg.sv
package pcs_seq_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MD_SGMII  = 3'd0;
  localparam logic [MODE_W-1:0] MD_QSGMII = 3'd1;
  localparam logic [MODE_W-1:0] MD_PSGMII = 3'd2;
  localparam logic [MODE_W-1:0] MD_USX    = 3'd3;
  localparam logic [MODE_W-1:0] MD_NONE   = 3'd7;

  localparam logic [ADDR_W-1:0] A_MODE    = 24'h00046C;
  localparam logic [ADDR_W-1:0] A_ANA     = 24'h000780;
  localparam logic [ADDR_W-1:0] A_CAL     = 24'h0001E0;
  localparam logic [ADDR_W-1:0] A_CH_BASE = 24'h000480;
  localparam logic [ADDR_W-1:0] A_CH_STEP = 24'h000018;
  localparam logic [ADDR_W-1:0] A_XDIG    = 24'h038000;
  localparam logic [ADDR_W-1:0] A_XANC    = 24'h1F8001;
  localparam logic [ADDR_W-1:0] A_XMII    = 24'h1F0000;

  localparam int MODE_LSB = 8;
  localparam int AN_BIT   = 0;
  localparam int ANA_BIT  = 6;
  localparam int CAL_BIT  = 7;
  localparam int FORCE_BIT = 3;
  localparam int XEN_BIT  = 9;
  localparam int XAN8_BIT = 8;
  localparam int XANEN_BIT = 12;

  function automatic logic mode_ok(input logic [MODE_W-1:0] m);
    return m <= MD_USX;
  endfunction

  function automatic logic [4:0] mode_field(input logic [MODE_W-1:0] m);
    case (m)
      MD_SGMII:  return 5'h04;
      MD_QSGMII: return 5'h01;
      MD_PSGMII: return 5'h02;
      MD_USX:    return 5'h10;
      default:   return 5'h00;
    endcase
  endfunction
endpackage

// File: rtl/pcs_seq_timer.sv
module pcs_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q && cnt_q < limit_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = run_q && (cnt_q >= limit_i);
endmodule

// File: rtl/pcs_rmw_master.sv
module pcs_rmw_master
  import pcs_seq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          rdonly_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] set_i,
  output logic          done_o,
  output logic          hit_o,      // read-only op: any masked bit read as 1
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i
);
  typedef enum logic [1:0] {R_IDLE, R_RD, R_WR} rst_e;
  rst_e          st_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] mask_q, set_q, wdata_q;
  logic          rdonly_q, done_q, hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= R_IDLE;
      addr_q   <= '0;
      mask_q   <= '0;
      set_q    <= '0;
      wdata_q  <= '0;
      rdonly_q <= 1'b0;
      done_q   <= 1'b0;
      hit_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        R_IDLE: if (go_i) begin
          addr_q   <= addr_i;
          mask_q   <= mask_i;
          set_q    <= set_i;
          rdonly_q <= rdonly_i;
          st_q     <= R_RD;
        end
        R_RD: if (bus_ack_i) begin
          wdata_q <= (bus_rdata_i & ~mask_q) | set_q;
          hit_q   <= |(bus_rdata_i & mask_q);
          if (rdonly_q) begin
            st_q   <= R_IDLE;
            done_q <= 1'b1;
          end else begin
            st_q <= R_WR;
          end
        end
        R_WR: if (bus_ack_i) begin
          st_q   <= R_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= R_IDLE;
      endcase
    end
  end

  assign bus_req_o   = (st_q != R_IDLE);
  assign bus_we_o    = (st_q == R_WR);
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign done_o      = done_q;
  assign hit_o       = hit_q;
endmodule

// File: rtl/pcs_mode_seq.sv
module pcs_mode_seq
  import pcs_seq_pkg::*;
#(
  parameter int CLK_KHZ = 200000,
  parameter int WAIT_MS = 10,
  parameter int POLL_MS = 1,
  parameter int TMO_MS  = 100,
  parameter int N_CH    = 5,
  localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              inband_i,
  input  logic [CH_W-1:0]   chan_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              xrst_o,
  output logic              done_o,
  output logic              err_o,
  output logic              rate_sel_o
);
  localparam int WAIT_CYC = CLK_KHZ * WAIT_MS;
  localparam int POLL_CYC = CLK_KHZ * POLL_MS;
  localparam int TMO_CYC  = CLK_KHZ * TMO_MS;
  localparam int DLY_MAX  = (WAIT_CYC > POLL_CYC) ? WAIT_CYC : POLL_CYC;
  localparam int DLY_W    = $clog2(DLY_MAX + 1);
  localparam int TMO_W    = $clog2(TMO_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_MODE, S_ANA_CLR, S_ANA_WAIT, S_ANA_SET, S_CAL_RD, S_CAL_GAP,
    S_XEN, S_XAN8, S_XANEN, S_FORCE
  } st_e;

  st_e               st_q;
  logic [MODE_W-1:0] cur_q, mode_q;
  logic              ib_q, issued_q, xrst_q, done_q, err_q, rate_q;
  logic [CH_W-1:0]   chan_q;

  logic              op_act, op_rd;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_mask, op_set;
  logic              rmw_go, rmw_done, rmw_hit;
  logic              dly_start, dly_exp, tmo_start, tmo_exp;
  logic [DLY_W-1:0]  dly_lim;
  logic              usx;

  assign usx = (mode_q == MD_USX);

  always_comb begin
    op_act  = 1'b1;
    op_rd   = 1'b0;
    op_addr = '0;
    op_mask = '0;
    op_set  = '0;
    case (st_q)
      S_MODE: begin
        op_addr = A_MODE;
        op_mask = (DATA_W'(5'h1F) << MODE_LSB) | (usx ? '0 : (DATA_W'(1) << AN_BIT));
        op_set  = DATA_W'(mode_field(mode_q)) << MODE_LSB;
      end
      S_ANA_CLR: begin
        op_addr = A_ANA;
        op_mask = DATA_W'(1) << ANA_BIT;
      end
      S_ANA_SET: begin
        op_addr = A_ANA;
        op_mask = DATA_W'(1) << ANA_BIT;
        op_set  = op_mask;
      end
      S_CAL_RD: begin
        op_rd   = 1'b1;
        op_addr = A_CAL;
        op_mask = DATA_W'(1) << CAL_BIT;
      end
      S_XEN: begin
        op_addr = A_XDIG;
        op_mask = DATA_W'(1) << XEN_BIT;
        op_set  = op_mask;
      end
      S_XAN8: begin
        op_addr = A_XANC;
        op_mask = DATA_W'(1) << XAN8_BIT;
        op_set  = op_mask;
      end
      S_XANEN: begin
        op_addr = A_XMII;
        op_mask = DATA_W'(1) << XANEN_BIT;
        op_set  = op_mask;
      end
      S_FORCE: begin
        op_addr = A_CH_BASE + ADDR_W'(chan_q) * A_CH_STEP;
        op_mask = DATA_W'(1) << FORCE_BIT;
        op_set  = op_mask;
      end
      default: op_act = 1'b0;
    endcase
  end

  assign rmw_go    = op_act && !issued_q;
  assign dly_start = rmw_done && ((st_q == S_ANA_CLR) ||
                                  (st_q == S_CAL_RD && !rmw_hit && !tmo_exp));
  assign tmo_start = rmw_done && (st_q == S_ANA_SET);
  assign dly_lim   = (st_q == S_ANA_WAIT) ? DLY_W'(WAIT_CYC) : DLY_W'(POLL_CYC);

  pcs_rmw_master u_rmw (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (rmw_go),
    .rdonly_i    (op_rd),
    .addr_i      (op_addr),
    .mask_i      (op_mask),
    .set_i       (op_set),
    .done_o      (rmw_done),
    .hit_o       (rmw_hit),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i),
    .bus_rdata_i (bus_rdata_i)
  );

  pcs_seq_timer #(.W(DLY_W)) u_dly (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (dly_start),
    .limit_i   (dly_lim),
    .expired_o (dly_exp)
  );

  pcs_seq_timer #(.W(TMO_W)) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (tmo_start),
    .limit_i   (TMO_W'(TMO_CYC)),
    .expired_o (tmo_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      cur_q    <= MD_NONE;
      mode_q   <= MD_NONE;
      ib_q     <= 1'b0;
      chan_q   <= '0;
      issued_q <= 1'b0;
      xrst_q   <= 1'b1;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rate_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (rmw_go)        issued_q <= 1'b1;
      else if (rmw_done) issued_q <= 1'b0;

      case (st_q)
        S_IDLE: if (start_i) begin
          if (!mode_ok(mode_i)) begin
            err_q <= 1'b1;
          end else if (mode_i == cur_q) begin
            done_q <= 1'b1;
          end else begin
            xrst_q <= 1'b1;
            mode_q <= mode_i;
            ib_q   <= inband_i;
            chan_q <= chan_i;
            st_q   <= S_MODE;
          end
        end
        S_MODE:     if (rmw_done) st_q <= S_ANA_CLR;
        S_ANA_CLR:  if (rmw_done) st_q <= S_ANA_WAIT;
        S_ANA_WAIT: if (dly_exp)  st_q <= S_ANA_SET;
        S_ANA_SET:  if (rmw_done) st_q <= S_CAL_RD;
        S_CAL_RD: if (rmw_done) begin
          if (rmw_hit) begin
            rate_q <= usx;
            if (usx) begin
              xrst_q <= 1'b0;
              st_q   <= S_XEN;
            end else if (!ib_q) begin
              st_q <= S_FORCE;
            end else begin
              cur_q  <= mode_q;
              done_q <= 1'b1;
              st_q   <= S_IDLE;
            end
          end else if (tmo_exp) begin
            err_q <= 1'b1;
            st_q  <= S_IDLE;
          end else begin
            st_q <= S_CAL_GAP;
          end
        end
        S_CAL_GAP: if (dly_exp) st_q <= S_CAL_RD;
        S_XEN: if (rmw_done) begin
          if (ib_q) begin
            st_q <= S_XAN8;
          end else begin
            cur_q  <= mode_q;
            done_q <= 1'b1;
            st_q   <= S_IDLE;
          end
        end
        S_XAN8: if (rmw_done) st_q <= S_XANEN;
        S_XANEN, S_FORCE: if (rmw_done) begin
          cur_q  <= mode_q;
          done_q <= 1'b1;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign xrst_o     = xrst_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign rate_sel_o = rate_q;
endmodule

// File: rtl/pcs_mode_seq_chk.sv
module pcs_mode_seq_chk
  import pcs_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_ack_i,
  input logic              xrst_o,
  input logic              done_o,
  input logic              err_o,
  input logic              rate_sel_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) &&
      $stable(bus_we_o) && $stable(bus_wdata_o)); // R6

  AST_MODE_WR_XRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && bus_addr_o == A_MODE |-> xrst_o); // R4

  AST_XEN_WR_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && bus_addr_o == A_XDIG |-> !xrst_o); // R11

  AST_XRST_FALL_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(xrst_o) |-> rate_sel_o); // R10

  AST_RESULT_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !bus_req_o); // R13

  AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R9
endmodule

bind pcs_mode_seq pcs_mode_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i),
  .xrst_o      (xrst_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .rate_sel_o  (rate_sel_o)
);

// File: tb/pcs_mode_seq_bench.sv
`timescale 1ns/1ps
module pcs_mode_seq_bench;
  localparam int KHZ  = 4;
  localparam int WAIT = KHZ * 10;
  localparam int POLL = KHZ * 1;
  localparam int TMO  = KHZ * 100;

  localparam int unsigned A_MODE = 32'h46C, A_ANA = 32'h780, A_CAL = 32'h1E0;
  localparam int unsigned A_XDIG = 32'h38000, A_XANC = 32'h1F8001, A_XMII = 32'h1F0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, inband = 1'b0;
  logic [2:0] mode = '0, chan = '0;
  logic bus_req, bus_we, bus_ack = 1'b0;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = '0;
  logic xrst, done, err, rate;

  always #2.5 clk = ~clk;

  pcs_mode_seq #(.CLK_KHZ(KHZ)) u_pcs_mode_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .inband_i(inband), .chan_i(chan), .bus_req_o(bus_req), .bus_we_o(bus_we),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack),
    .bus_rdata_i(bus_rdata), .xrst_o(xrst), .done_o(done), .err_o(err),
    .rate_sel_o(rate)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [31:0] regs [int unsigned];
  logic [31:0] snap [int unsigned];
  int n_rd, n_wr, ana_clr_cyc, ana_set_cyc, last_cal, min_gap, cal_reads, cal_delay;
  bit cal_ok, first_wr_xrst;
  logic [2:0] cur;
  bit cur_valid;
  bit cur_rate;

  function automatic logic [31:0] rd_reg(int unsigned a);
    return regs.exists(a) ? regs[a] : 32'h0;
  endfunction

  function automatic logic [4:0] exp_field(logic [2:0] m);
    case (m) 3'd0: return 5'h04; 3'd1: return 5'h01; 3'd2: return 5'h02; default: return 5'h10; endcase
  endfunction

  function automatic int unsigned ch_addr(int c);
    return 32'h480 + 32'h18 * c;
  endfunction

  // register target model
  initial forever begin
    @(negedge clk);
    cyc++;
    if (!rst_n || bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_req) begin
      bus_ack = 1'b1;
      if (bus_we) begin
        n_wr++;
        if (n_wr == 1) first_wr_xrst = xrst;
        regs[int'(bus_addr)] = bus_wdata;
        if (bus_addr == A_ANA) begin
          if (bus_wdata[6]) ana_set_cyc = cyc; else ana_clr_cyc = cyc;
        end
      end else begin
        logic [31:0] d;
        n_rd++;
        d = rd_reg(int'(bus_addr));
        if (bus_addr == A_CAL) begin
          d[7] = cal_ok && ana_set_cyc >= 0 && (cyc - ana_set_cyc >= cal_delay);
          if (last_cal >= 0 && cyc - last_cal < min_gap) min_gap = cyc - last_cal;
          last_cal = cyc;
          cal_reads++;
        end
        bus_rdata = d;
      end
    end
  end

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic clr_stats();
    n_rd = 0; n_wr = 0; ana_clr_cyc = -1; ana_set_cyc = -1; last_cal = -1;
    min_gap = 1 << 30; cal_reads = 0; first_wr_xrst = 1'b0;
  endtask

  task automatic preload();
    int unsigned al[11];
    al = '{A_MODE, A_ANA, A_CAL, A_XDIG, A_XANC, A_XMII,
           ch_addr(0), ch_addr(1), ch_addr(2), ch_addr(3), ch_addr(4)};
    foreach (al[i]) regs[al[i]] = $urandom;
    regs[A_ANA][6] = 1'b1;
    snap = regs;
  endtask

  task automatic kick(logic [2:0] m, bit ib, logic [2:0] ch, output int lat,
                      output bit gd, output bit ge);
    @(negedge clk);
    mode = m; inband = ib; chan = ch; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && !err && lat < 5000) begin @(negedge clk); lat++; end
    gd = done; ge = err;
  endtask

  task automatic run_full(logic [2:0] m, bit ib, logic [2:0] ch);
    int lat; bit gd, ge; logic [31:0] mask, e;
    preload(); clr_stats();
    cal_ok = 1'b1; cal_delay = $urandom_range(0, 30);
    kick(m, ib, ch, lat, gd, ge);
    chk(gd && !ge, "R13", "done without err", {gd, ge}, 2'b10);
    chk(first_wr_xrst, "R4", "xrst before first write", first_wr_xrst, 1);
    chk(n_rd >= n_wr, "R6", "read precedes each write", n_rd, n_wr);
    mask = 32'h1F00 | ((m == 3) ? 32'h0 : 32'h1);
    e = (snap[A_MODE] & ~mask) | (32'(exp_field(m)) << 8);
    chk(regs[A_MODE] == e, "R5", "mode register", regs[A_MODE], e);
    e = snap[A_ANA];
    chk(regs[A_ANA] == e, "R7", "analog reg restored", regs[A_ANA], e);
    chk(ana_clr_cyc >= 0 && ana_set_cyc - ana_clr_cyc >= WAIT, "R7", "reset pulse length",
        ana_set_cyc - ana_clr_cyc, WAIT);
    chk(cal_reads <= 1 || min_gap >= POLL, "R8", "poll gap", min_gap, POLL);
    chk(rate == (m == 3), "R10", "rate select", rate, m == 3);
    if (m == 3) begin
      chk(xrst == 1'b0, "R11", "sub-PCS released", xrst, 0);
      e = snap[A_XDIG] | (32'h1 << 9);
      chk(regs[A_XDIG] == e, "R11", "usx enable", regs[A_XDIG], e);
      e = ib ? (snap[A_XANC] | (32'h1 << 8)) : snap[A_XANC];
      chk(regs[A_XANC] == e, "R11", "an 8bit", regs[A_XANC], e);
      e = ib ? (snap[A_XMII] | (32'h1 << 12)) : snap[A_XMII];
      chk(regs[A_XMII] == e, "R11", "an enable", regs[A_XMII], e);
    end else begin
      chk(xrst == 1'b1, "R12", "sub-PCS held", xrst, 1);
      for (int c = 0; c < 5; c++) begin
        e = (!ib && c == ch) ? (snap[ch_addr(c)] | 32'h8) : snap[ch_addr(c)];
        chk(regs[ch_addr(c)] == e, "R12", "channel ctrl", regs[ch_addr(c)], e);
      end
      chk(regs[A_XDIG] == snap[A_XDIG], "R12", "usx reg untouched", regs[A_XDIG], snap[A_XDIG]);
    end
    @(negedge clk);
    chk(!done, "R13", "done single pulse", done, 0);
    cur = m; cur_valid = 1'b1; cur_rate = (m == 3);
  endtask

  task automatic run_same(bit ib);
    int lat; bit gd, ge;
    clr_stats();
    kick(cur, ib, 3'd1, lat, gd, ge);
    chk(gd && lat == 1, "R3", "same mode done latency", lat, 1);
    chk(n_rd + n_wr == 0, "R3", "same mode bus accesses", n_rd + n_wr, 0);
  endtask

  task automatic run_bad(logic [2:0] m);
    int lat; bit gd, ge;
    clr_stats();
    kick(m, 1'b0, 3'd0, lat, gd, ge);
    chk(ge && !gd && lat == 1, "R2", "unsupported err latency", lat, 1);
    chk(n_rd + n_wr == 0, "R2", "unsupported bus accesses", n_rd + n_wr, 0);
    clr_stats();
    kick(cur, 1'b0, 3'd0, lat, gd, ge);
    chk(gd && lat == 1 && n_rd + n_wr == 0, "R2", "stored mode kept", lat, 1);
  endtask

  task automatic run_tmo(logic [2:0] m);
    int lat, rd0; bit gd, ge;
    preload(); clr_stats();
    cal_ok = 1'b0; cal_delay = 0;
    kick(m, 1'b0, 3'd2, lat, gd, ge);
    chk(ge && !gd, "R9", "timeout err", {gd, ge}, 2'b01);
    chk(lat >= WAIT + TMO, "R9", "timeout not early", lat, WAIT + TMO);
    chk(cal_reads >= 2, "R8", "repeated polls", cal_reads, 2);
    chk(rate == cur_rate, "R9", "rate unchanged", rate, cur_rate);
    rd0 = n_rd + n_wr;
    repeat (20) @(negedge clk);
    chk(n_rd + n_wr == rd0 && !bus_req, "R9", "bus quiet after err", n_rd + n_wr, rd0);
    cal_ok = 1'b1;
    run_same(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7019));
    cur_valid = 1'b0; cur = 3'd7; cur_rate = 1'b0;
    clr_stats();
    repeat (3) @(negedge clk);
    chk(!done && !err && !bus_req && !rate && xrst, "R1", "reset outputs",
        {done, err, bus_req, rate, xrst}, 5'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && xrst, "R1", "idle after reset", {bus_req, xrst}, 2'b01);
    run_full(3'd0, 1'b0, 3'd4);
    run_same(1'b1);
    run_bad(3'd5);
    run_bad(3'd7);
    run_full(3'd3, 1'b1, 3'd0);
    run_full(3'd2, 1'b1, 3'd1);
    run_full(3'd3, 1'b0, 3'd2);
    run_tmo(3'd1);
    run_full(3'd1, 1'b0, 3'd0);
    for (int i = 0; i < 10; i++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 3));
      if (m == cur) run_same(1'($urandom));
      else run_full(m, 1'($urandom), 3'($urandom_range(0, 4)));
    end
    run_bad(3'd4);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule